// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address for each access of a short burst on a synchronous memory port. The caller supplies one starting address, and the block then steps the low address bits through up to four beats. The bits above the burst field stay exactly as they were loaded. Two beat orders are available. The linear order counts upward and wraps inside the burst field. The interleaved order combines the starting bits with the beat number by XOR.

A load takes place on an enabled clock edge when the advance/load input is low. The same edge also captures the read/write type of the burst from the write-enable sample. Every later beat keeps that type, whatever the write-enable input does. An enabled edge with advance/load high moves the burst on by one beat. Nothing else gates an advance, so chip-select or write-enable state in the surrounding logic has no effect on it. While the active-low clock-enable is high, the block holds all of its state.

The order select is meant to be a static strap. It acts on the output combinationally, through the current beat. A library parameter can remove either order from the logic.

Top module: `bseq_top`

## Requirements
- R1: After reset is released, and before any enabled edge, `cur_addr` is all zeros and `acc_write` is 0 (read).
- R2: When `cke_n` is 0 and `adv_ld` is 0 at a rising edge, `cur_addr` equals the `addr_in` from that edge in the following cycle. `acc_write` then equals the inverse of the sampled `wr_n`: 1 means a write, 0 means a read.
- R3: When `cke_n` is 0 and `adv_ld` is 1 at a rising edge, the burst moves on by exactly one beat. The value of `wr_n` and the value of `addr_in` have no influence on this step.
- R4: With `order_sel` = 0 (linear), the two low bits of `cur_addr` equal the loaded low bits plus the beat count, modulo 4. No carry reaches bit 2 or higher.
- R5: With `order_sel` = 1 (interleaved), the two low bits of `cur_addr` equal the loaded low bits XOR the beat count.
- R6: `acc_write` keeps its loaded value through every advance, even when `wr_n` changes.
- R7: When `cke_n` is 1 at a rising edge, neither `cur_addr` nor `acc_write` changes. This holds whatever `adv_ld`, `addr_in` and `wr_n` show.
- R8: Bits 2 and higher of `cur_addr` keep their loaded value through every advance.
- R9: After four advances from a load, the two low bits return to the loaded low bits. This holds in both orders.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke_n | input | 1 | Active-low clock enable; high freezes all state |
| adv_ld | input | 1 | 0 loads a new start address, 1 advances one beat |
| addr_in | input | ADDR_W (21) | Start address sampled on a load |
| order_sel | input | 1 | Beat order: 0 linear, 1 interleaved |
| wr_n | input | 1 | Active-low write sample, captured on a load |
| cur_addr | output | ADDR_W (21) | Address of the current beat |
| acc_write | output | 1 | Burst type latched at load: 1 write, 0 read |

## Verification
The hardest case to reach is the wrap, where the linear sum overflows the burst field. Carry into bit 2 would appear only there, and only when the upper bits form a pattern that shows a stray increment. The stimulus loads a start address whose low bits are 3 and whose upper bits are an alternating pattern. It then advances five times, so the low bits cross 3→0 and then come back to the start. During those advances `wr_n` toggles and `addr_in` is changed to unrelated values, so any leak of those inputs into the burst would show at the output. A separate pass applies the same long advance run in interleaved order from a different starting offset.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

   // Run-time beat order chosen by the order select input
   typedef enum logic {
      ORD_LINEAR = 1'b0,
      ORD_XOR    = 1'b1
   } order_e;

   // Which orders the mapper implements
   typedef enum logic [1:0] {
      VAR_BOTH   = 2'd0,
      VAR_LINEAR = 2'd1,
      VAR_XOR    = 2'd2
   } variant_e;

endpackage

// File: rtl/bseq_state.sv
// Holds the burst start address and the burst access type.
module bseq_state #(
   parameter int ADDR_W = 21
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_en,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic              wr_n,
   output logic [ADDR_W-1:0] start_q,
   output logic              write_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_q <= '0;
         write_q <= 1'b0;
      end else if (load_en) begin
         start_q <= addr_in;
         write_q <= ~wr_n;
      end
   end

endmodule

// File: rtl/bseq_beat.sv
// Beat counter: cleared on load, wraps naturally on advance.
module bseq_beat #(
   parameter int BB = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_en,
   input  logic          adv_en,
   output logic [BB-1:0] beat_q
);

   localparam logic [BB-1:0] STEP = BB'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         beat_q <= '0;
      end else if (load_en) begin
         beat_q <= '0;
      end else if (adv_en) begin
         beat_q <= beat_q + STEP;
      end
   end

endmodule

// File: rtl/bseq_map.sv
// Maps start bits and beat count to the low address bits.
module bseq_map
   import bseq_pkg::*;
#(
   parameter int       BB      = 2,
   parameter variant_e VARIANT = VAR_BOTH
) (
   input  logic          order_sel,
   input  logic [BB-1:0] start_lo,
   input  logic [BB-1:0] beat,
   output logic [BB-1:0] lo_out
);

   logic [BB-1:0] lin_lo;
   logic [BB-1:0] xor_lo;

   // The sum is truncated to BB bits, so no carry leaves the field
   assign lin_lo = start_lo + beat;
   assign xor_lo = start_lo ^ beat;

   generate
      if (VARIANT == VAR_BOTH) begin : g_both
         always_comb begin
            if (order_e'(order_sel) == ORD_XOR) lo_out = xor_lo;
            else                                lo_out = lin_lo;
         end
      end else if (VARIANT == VAR_LINEAR) begin : g_lin
         logic unused_sel;
         logic [BB-1:0] unused_xor;
         assign unused_sel = order_sel;
         assign unused_xor = xor_lo;
         assign lo_out     = lin_lo;
      end else begin : g_xor
         logic unused_sel;
         logic [BB-1:0] unused_lin;
         assign unused_sel = order_sel;
         assign unused_lin = lin_lo;
         assign lo_out     = xor_lo;
      end
   endgenerate

endmodule

// File: rtl/bseq_top.sv
module bseq_top
   import bseq_pkg::*;
#(
   parameter int       ADDR_W  = 21,
   parameter int       BB      = 2,
   parameter variant_e VARIANT = VAR_BOTH
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cke_n,
   input  logic              adv_ld,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic              order_sel,
   input  logic              wr_n,
   output logic [ADDR_W-1:0] cur_addr,
   output logic              acc_write
);

   localparam int UPPER_W = ADDR_W - BB;

   generate
      if (BB < 1 || BB > 4) begin : g_bad_bb
         $error("bseq_top: BB must lie in 1..4");
      end
      if (UPPER_W < 1) begin : g_bad_aw
         $error("bseq_top: ADDR_W must exceed BB");
      end
   endgenerate

   logic              load_en;
   logic              adv_en;
   logic [ADDR_W-1:0] start_q;
   logic [BB-1:0]     beat_q;
   logic [BB-1:0]     lo_bits;

   assign load_en = ~cke_n & ~adv_ld;
   assign adv_en  = ~cke_n &  adv_ld;

   bseq_state #(.ADDR_W(ADDR_W)) u_state (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_en (load_en),
      .addr_in (addr_in),
      .wr_n    (wr_n),
      .start_q (start_q),
      .write_q (acc_write)
   );

   bseq_beat #(.BB(BB)) u_beat (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_en (load_en),
      .adv_en  (adv_en),
      .beat_q  (beat_q)
   );

   bseq_map #(.BB(BB), .VARIANT(VARIANT)) u_map (
      .order_sel (order_sel),
      .start_lo  (start_q[BB-1:0]),
      .beat      (beat_q),
      .lo_out    (lo_bits)
   );

   assign cur_addr = {start_q[ADDR_W-1:BB], lo_bits};

endmodule

// File: rtl/bseq_chk.sv
module bseq_chk #(
   parameter int ADDR_W = 21,
   parameter int BB     = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cke_n,
   input logic              adv_ld,
   input logic              order_sel,
   input logic [ADDR_W-1:0] addr_in,
   input logic [ADDR_W-1:0] cur_addr,
   input logic              acc_write,
   input logic [ADDR_W-1:0] start_q,
   input logic [BB-1:0]     beat_q
);

   localparam logic [BB-1:0] ONE = BB'(1);

   // R2: a load presents the supplied address in the next cycle
   p_load_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!cke_n && !adv_ld) |=> (cur_addr == $past(addr_in)));

   // R7: disabled clock freezes the state
   p_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cke_n |=> ($stable(start_q) && $stable(beat_q) && $stable(acc_write)));

   // R6: burst type survives advances
   p_type_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!cke_n && adv_ld) |=> $stable(acc_write));

   // R8: upper bits stay fixed while advancing
   p_upper_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!cke_n && adv_ld) |=> $stable(cur_addr[ADDR_W-1:BB]));

   // R4: linear step adds one inside the field
   p_lin_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!cke_n && adv_ld && !order_sel) |=>
         (order_sel || (cur_addr[BB-1:0] == $past(cur_addr[BB-1:0]) + ONE)));

endmodule

bind bseq_top bseq_chk #(.ADDR_W(ADDR_W), .BB(BB)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cke_n     (cke_n),
   .adv_ld    (adv_ld),
   .order_sel (order_sel),
   .addr_in   (addr_in),
   .cur_addr  (cur_addr),
   .acc_write (acc_write),
   .start_q   (start_q),
   .beat_q    (beat_q)
);

// File: tb/sim_bseq_top.sv
`timescale 1ns/1ps
module sim_bseq_top;

   localparam int AW = 21;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cke_n = 1'b1;
   logic          adv_ld = 1'b1;
   logic [AW-1:0] addr_in = '0;
   logic          order_sel = 1'b0;
   logic          wr_n = 1'b1;
   logic [AW-1:0] cur_addr;
   logic          acc_write;

   int checks = 0;
   int errors = 0;

   // bench-side model of the burst
   logic [AW-1:0] m_start = '0;
   int            m_beat = 0;
   logic          m_wr = 1'b0;

   always #5 clk = ~clk;

   bseq_top u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .cke_n     (cke_n),
      .adv_ld    (adv_ld),
      .addr_in   (addr_in),
      .order_sel (order_sel),
      .wr_n      (wr_n),
      .cur_addr  (cur_addr),
      .acc_write (acc_write)
   );

   function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] s, input int b, input logic ord);
      logic [1:0] lo;
      logic [1:0] bb;
      bb = 2'(b % 4);
      if (ord) lo = s[1:0] ^ bb;
      else     lo = 2'((int'(s[1:0]) + int'(bb)) % 4);
      return {s[AW-1:2], lo};
   endfunction

   task automatic chk(input string req, input logic [AW-1:0] exp_a, input logic exp_w);
      checks++;
      if (cur_addr !== exp_a || acc_write !== exp_w) begin
         errors++;
         $display("FAIL %s: addr=%h write=%b expected addr=%h write=%b",
                  req, cur_addr, acc_write, exp_a, exp_w);
      end
   endtask

   // one clock with given inputs; inputs change at negedge, result read at next negedge
   task automatic cyc(input logic ck, input logic al, input logic [AW-1:0] a, input logic w);
      cke_n = ck; adv_ld = al; addr_in = a; wr_n = w;
      @(negedge clk);
      if (!ck) begin
         if (!al) begin m_start = a; m_beat = 0; m_wr = ~w; end
         else     m_beat++;
      end
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      m_start = '0; m_beat = 0; m_wr = 1'b0;
      chk("R1 reset", '0, 1'b0);
   endtask

   task automatic t_load();
      cyc(1'b0, 1'b0, 21'h0ABCDE, 1'b1);
      chk("R2 load read", 21'h0ABCDE, 1'b0);
      cyc(1'b0, 1'b0, 21'h155551, 1'b0);
      chk("R2 load write", 21'h155551, 1'b1);
   endtask

   task automatic t_linear_wrap();
      order_sel = 1'b0;
      cyc(1'b0, 1'b0, 21'h0AAAAB, 1'b1); // low bits 3
      chk("R4 linear beat0", exp_addr(m_start, m_beat, 1'b0), m_wr);
      for (int i = 1; i <= 5; i++) begin
         cyc(1'b0, 1'b1, 21'(i * 21'h01F3C7), i[0]);
         chk("R3 R4 R8 linear advance", exp_addr(m_start, m_beat, 1'b0), m_wr);
         if (i == 1) chk("R4 no carry", {21'h0AAAAB >> 2, 2'b00}, 1'b0);
         if (i == 4) chk("R9 linear wrap", 21'h0AAAAB, 1'b0);
      end
   endtask

   task automatic t_interleave();
      order_sel = 1'b1;
      cyc(1'b0, 1'b0, 21'h12345D, 1'b1); // low bits 1
      chk("R5 xor beat0", exp_addr(m_start, m_beat, 1'b1), m_wr);
      for (int i = 1; i <= 5; i++) begin
         cyc(1'b0, 1'b1, 21'h1FFFFF, 1'b0);
         chk("R5 R8 xor advance", exp_addr(m_start, m_beat, 1'b1), m_wr);
         if (i == 2) chk("R5 xor beat2", 21'h12345F, 1'b0);
         if (i == 4) chk("R9 xor wrap", 21'h12345D, 1'b0);
      end
   endtask

   task automatic t_type_hold();
      order_sel = 1'b0;
      cyc(1'b0, 1'b0, 21'h000010, 1'b0); // write burst
      for (int i = 0; i < 3; i++) begin
         cyc(1'b0, 1'b1, 21'h000000, i[0]);
         chk("R6 write kept", exp_addr(m_start, m_beat, 1'b0), 1'b1);
      end
      cyc(1'b0, 1'b0, 21'h000020, 1'b1); // read burst
      cyc(1'b0, 1'b1, 21'h000000, 1'b0);
      chk("R6 read kept", 21'h000021, 1'b0);
   endtask

   task automatic t_freeze();
      order_sel = 1'b0;
      cyc(1'b0, 1'b0, 21'h0F0F02, 1'b1);
      cyc(1'b0, 1'b1, 21'h0F0F02, 1'b1);
      cyc(1'b1, 1'b0, 21'h1C3C3C, 1'b0); // would load a write if enabled
      chk("R7 hold on load", 21'h0F0F03, 1'b0);
      cyc(1'b1, 1'b1, 21'h000000, 1'b0);
      chk("R7 hold on advance", 21'h0F0F03, 1'b0);
      cyc(1'b0, 1'b1, 21'h000000, 1'b1);
      chk("R7 resume", 21'h0F0F00, 1'b0);
   endtask

   initial begin
      @(negedge clk);
      t_reset();
      t_load();
      t_linear_wrap();
      t_interleave();
      t_type_hold();
      t_freeze();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule